// File: doc/BRIEF.md
# Bidirectional Pad Boundary-Scan Segment

This block is the boundary-scan slice for a single bidirectional pad. It holds three scan stages on one serial path. The first stage observes the pad input. The second stage carries the value meant for the pad driver. The third stage carries the enable for the pad driver. Each stage has a flop that either shifts serial data or captures a parallel value on the rising test-clock edge. The driver value stage and the enable stage also have an update latch that loads on the falling test-clock edge.

A select input chooses where the pad driver value and the driver enable come from. When the select is high (external test), they come from the update latches. When it is low, the core drives the pad as in normal operation. The value seen on the pad is always passed to the core. The serial output is retimed on the falling edge. Decoding of the test controller and the instruction is done outside this block, and all strobes arrive already decoded.

Top module: `bscan_bidir_seg`

## Requirements
- R1: An active-high asynchronous `rst` clears the three capture flops, the serial output and the data update latch to 0. It sets the direction update latch to 1, which means high impedance.
- R2: On a rising `tck` edge with `shift_sel`=1, the data moves one place along the chain in this order: `si` to the input cell, the input cell to the data cell, and the data cell to the direction cell.
- R3: On a rising `tck` edge with `shift_sel`=0 and `cap_en`=1, the cells load their parallel values. The input cell loads `pad_in`, the data cell loads `core_out` and the direction cell loads `core_tri`.
- R4: On a rising `tck` edge with `shift_sel`=0 and `cap_en`=0, all three capture flops keep their values.
- R5: `so` changes only on the falling `tck` edge. It then takes the value that the direction cell holds at that edge.
- R6: On a falling `tck` edge with `upd`=1, the data latch loads the data cell and the direction latch loads the direction cell. With `upd`=0 both latches keep their values.
- R7: With `mode`=1, `pad_out` equals the data update latch and `pad_tri` equals the direction update latch. In this state the core inputs have no effect on the pad.
- R8: With `mode`=0, `pad_out` follows `core_out` and `pad_tri` follows `core_tri`.
- R9: `core_in` always follows `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Asynchronous reset, active high |
| shift_sel | input | 1 | 1 = shift the serial data, 0 = capture the parallel values |
| cap_en | input | 1 | Enables the parallel capture when `shift_sel` is 0 |
| upd | input | 1 | Update strobe, sampled on the falling `tck` edge |
| mode | input | 1 | 1 = the update latches drive the pad, 0 = the core drives the pad |
| si | input | 1 | Serial input to the input cell |
| so | output | 1 | Serial output from the direction cell, retimed on the falling edge |
| core_out | input | 1 | Value from the core for the pad driver |
| core_tri | input | 1 | Driver enable from the core (1 = high impedance) |
| core_in | output | 1 | Pad value passed to the core |
| pad_in | input | 1 | Value received from the pad |
| pad_out | output | 1 | Value sent to the pad driver |
| pad_tri | output | 1 | Driver enable sent to the pad (1 = high impedance) |

## Verification
A walking pattern of alternating ones and zeros is shifted through the chain. Its arrival on `so` distinguishes the correct cell order from a swapped one, and a wrong clock edge from the right one. The update strobe is then pulsed and held off while external test is selected. Because each step changes the capture flops, this separates latches that load only on the strobe from latches that always load. One step captures while the update is pulsed, which shows whether the update sees the freshly captured value. Other steps capture with the enable off, and reset is applied after the capture flops have been filled with ones; these steps expose a capture that ignores the enable and flops that escape reset. Steps with the select low carry core values that differ from the latch contents, so any mix-up in the pad multiplexers shows at the pad pins.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
    localparam int NCELL = 3;

    typedef enum logic [1:0] {
        CELL_IN  = 2'd0,
        CELL_DAT = 2'd1,
        CELL_DIR = 2'd2
    } cell_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_CAPT  = 2'd2
    } cap_op_e;

    localparam logic RST_CAP = 1'b0;
    localparam logic RST_DAT = 1'b0;
    localparam logic RST_DIR = 1'b1;
endpackage

// File: rtl/bscan_cap_cell.sv
module bscan_cap_cell
    import bscan_pkg::*;
#(
    parameter logic RST_VAL = RST_CAP
) (
    input  logic tck,
    input  logic rst,
    input  logic shift_sel,
    input  logic cap_en,
    input  logic ser_in,
    input  logic par_in,
    output logic q
);
    cap_op_e op;

    always_comb begin
        if (shift_sel)   op = OP_SHIFT;
        else if (cap_en) op = OP_CAPT;
        else             op = OP_HOLD;
    end

    always_ff @(posedge tck or posedge rst) begin
        if (rst) begin
            q <= RST_VAL;
        end else begin
            unique case (op)
                OP_SHIFT: q <= ser_in;
                OP_CAPT:  q <= par_in;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/bscan_upd_cell.sv
module bscan_upd_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic tck,
    input  logic rst,
    input  logic upd,
    input  logic d,
    output logic q
);
    always_ff @(negedge tck or posedge rst) begin
        if (rst)      q <= RST_VAL;
        else if (upd) q <= d;
    end
endmodule

// File: rtl/bscan_bidir_seg.sv
module bscan_bidir_seg
    import bscan_pkg::*;
(
    input  logic tck,
    input  logic rst,
    input  logic shift_sel,
    input  logic cap_en,
    input  logic upd,
    input  logic mode,
    input  logic si,
    output logic so,
    input  logic core_out,
    input  logic core_tri,
    output logic core_in,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_tri
);
    logic [NCELL-1:0] cap_q;
    logic [NCELL-1:0] par_v;
    logic [NCELL-1:0] ser_v;
    logic             upd_dat;
    logic             upd_dir;

    assign par_v[CELL_IN]  = pad_in;
    assign par_v[CELL_DAT] = core_out;
    assign par_v[CELL_DIR] = core_tri;
    assign ser_v           = {cap_q[NCELL-2:0], si};

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        bscan_cap_cell #(.RST_VAL(RST_CAP)) u_cap (
            .tck      (tck),
            .rst      (rst),
            .shift_sel(shift_sel),
            .cap_en   (cap_en),
            .ser_in   (ser_v[i]),
            .par_in   (par_v[i]),
            .q        (cap_q[i])
        );
    end

    bscan_upd_cell #(.RST_VAL(RST_DAT)) u_upd_dat (
        .tck(tck), .rst(rst), .upd(upd), .d(cap_q[CELL_DAT]), .q(upd_dat)
    );

    bscan_upd_cell #(.RST_VAL(RST_DIR)) u_upd_dir (
        .tck(tck), .rst(rst), .upd(upd), .d(cap_q[CELL_DIR]), .q(upd_dir)
    );

    always_ff @(negedge tck or posedge rst) begin
        if (rst) so <= 1'b0;
        else     so <= cap_q[CELL_DIR];
    end

    always_comb begin
        pad_out = mode ? upd_dat : core_out;
        pad_tri = mode ? upd_dir : core_tri;
    end

    assign core_in = pad_in;
endmodule

// File: rtl/bscan_seg_chk.sv
module bscan_seg_chk (
    input logic       tck,
    input logic       rst,
    input logic       shift_sel,
    input logic       upd,
    input logic       mode,
    input logic       so,
    input logic       core_out,
    input logic       core_tri,
    input logic       core_in,
    input logic       pad_in,
    input logic       pad_out,
    input logic       pad_tri,
    input logic [2:0] cap_q,
    input logic       upd_dat,
    input logic       upd_dir
);
    AST_SHIFT_ORDER: assert property (@(posedge tck) disable iff (rst)
        shift_sel |=> (cap_q[2] == $past(cap_q[1]) && cap_q[1] == $past(cap_q[0]))); // R2

    AST_SO_RETIME: assert property (@(negedge tck) disable iff (rst)
        1'b1 |=> (so == $past(cap_q[2]))); // R5

    AST_UPD_LOAD: assert property (@(negedge tck) disable iff (rst)
        upd |=> (upd_dat == $past(cap_q[1]) && upd_dir == $past(cap_q[2]))); // R6

    AST_UPD_HOLD: assert property (@(negedge tck) disable iff (rst)
        !upd |=> ($stable(upd_dat) && $stable(upd_dir))); // R6

    AST_EXTEST_PAD: assert property (@(posedge tck) disable iff (rst)
        mode |-> (pad_out == upd_dat && pad_tri == upd_dir)); // R7

    AST_CORE_PAD: assert property (@(posedge tck) disable iff (rst)
        !mode |-> (pad_out == core_out && pad_tri == core_tri)); // R8

    AST_PAD_TO_CORE: assert property (@(posedge tck) disable iff (rst)
        core_in == pad_in); // R9
endmodule

bind bscan_bidir_seg bscan_seg_chk u_chk (
    .tck(tck), .rst(rst), .shift_sel(shift_sel), .upd(upd), .mode(mode),
    .so(so), .core_out(core_out), .core_tri(core_tri), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_tri(pad_tri),
    .cap_q(cap_q), .upd_dat(upd_dat), .upd_dir(upd_dir)
);

// File: tb/sim_bscan_bidir_seg.sv
module sim_bscan_bidir_seg;
    logic tck = 1'b0;
    logic rst, shift_sel, cap_en, upd, mode, si;
    logic core_out, core_tri, pad_in;
    logic so, core_in, pad_out, pad_tri;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2 tck = ~tck;

    bscan_bidir_seg u0 (
        .tck(tck), .rst(rst), .shift_sel(shift_sel), .cap_en(cap_en),
        .upd(upd), .mode(mode), .si(si), .so(so),
        .core_out(core_out), .core_tri(core_tri), .core_in(core_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_tri(pad_tri)
    );

    // {shift_sel, cap_en, upd, mode, si, core_out, core_tri, pad_in,
    //  exp_so, exp_pad_out, exp_pad_tri, exp_core_in}
    localparam int NV = 15;
    localparam logic [11:0] VEC [NV] = '{
        12'b1000_1100_0100, // R2 shift a 1 in, R8 core drives the pad
        12'b1000_0011_0011, // R2
        12'b1000_1110_1110, // R2 R5 the first 1 reaches so
        12'b1000_0001_0001, // R2
        12'b1011_1100_1010, // R6 update, R7 core values ignored
        12'b1001_1001_0011, // R6 hold without the strobe
        12'b1011_0000_1110, // R6
        12'b1011_0000_1010, // R6
        12'b1011_1000_0000, // R6 enable latch loads 0
        12'b1011_0000_0100, // R6 R7
        12'b0101_0011_1101, // R3 capture pad_in, core_out, core_tri
        12'b1001_0000_0100, // R2
        12'b0000_0111_0111, // R4 hold with the capture enable off, R8
        12'b1000_0000_1000, // R4 the held data bit shifts out
        12'b0111_0100_0100  // R3 R6 capture and update in one step
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; shift_sel = 0; cap_en = 0; upd = 0; mode = 1; si = 0;
        core_out = 1; core_tri = 0; pad_in = 0;
        #9;
        chk("R1 so", so, 1'b0);
        chk("R1 pad_out", pad_out, 1'b0);
        chk("R1 pad_tri", pad_tri, 1'b1);
        @(negedge tck); #1;
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            {shift_sel, cap_en, upd, mode, si, core_out, core_tri, pad_in} = VEC[v][11:4];
            step();
            chk("R5 so", so, VEC[v][3]);
            chk(mode ? "R7 pad_out" : "R8 pad_out", pad_out, VEC[v][2]);
            chk(mode ? "R7 pad_tri" : "R8 pad_tri", pad_tri, VEC[v][1]);
            chk("R9 core_in", core_in, VEC[v][0]);
        end

        // R1: fill the capture flops with ones, reset in mid-cycle, then shift zeros out
        shift_sel = 0; cap_en = 1; upd = 1; mode = 1;
        pad_in = 1; core_out = 1; core_tri = 1;
        step();
        chk("R3 so after capture", so, 1'b1);
        chk("R7 pad_out after update", pad_out, 1'b1);
        #1 rst = 1'b1;
        #0.5;
        chk("R1 so async", so, 1'b0);
        chk("R1 pad_out async", pad_out, 1'b0);
        chk("R1 pad_tri async", pad_tri, 1'b1);
        @(negedge tck); #1;
        rst = 1'b0; shift_sel = 1; cap_en = 0; upd = 0; si = 0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R1 cleared capture flop", so, 1'b0);
        end

        // R8: the core drives the pad directly when mode is low
        mode = 0; core_out = 1; core_tri = 0;
        #1;
        chk("R8 pad_out", pad_out, 1'b1);
        chk("R8 pad_tri", pad_tri, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule